// File: doc/BRIEF.md
# Host Bridge Control Register Bank

This block is the 32-bit control and status register bank of a CPU-to-PCI host bridge. It answers in a 4 KB byte window. The word index comes from byte address bits [11:2]. On each write the bank applies a mask that belongs to the addressed register. Read-only registers take no notice of writes. A write to the low-decode register of an address window also loads that window's remap register in the same cycle.

For every address window the current low-decode and high-decode values leave the block as flat vectors, so a window decoder next to it can match CPU addresses without a bus read. Reads of the sync-barrier registers return a fixed pattern. The error-capture and ECC registers hold their reset contents. A build-time option byte-reverses the data in both directions at the bus edge for a big-endian CPU, and the same option also changes some reset values.

The bus is a plain single-cycle interface with address, write data, write enable and read enable. Read data is registered.

Top module: `hbr_regfile`

## Requirements
- R1: The register is selected by byte address bits [11:2]. Address bits [1:0] have no effect, so an access at byte 0x44F reaches the same word as one at 0x44C.
- R2: A write to a window's low-decode register stores the data ANDed with 0x00007FFF. In the same cycle the data ANDed with 0x000007FF goes into that window's remap register. The low-decode offsets are 0x048, 0x058, 0x080, 0x090, 0x0A0 and 0x0B0, and the remap offsets are 0x0F0, 0x0F8, 0x100, 0x108, 0x110 and 0x118, both in window order 0 to 5.
- R3: Writes to the high-decode registers (0x050, 0x060, 0x088, 0x098, 0x0A8, 0x0B8) are ANDed with 0x0000007F. Direct writes to a remap register are ANDed with 0x000007FF and leave the low-decode register unchanged.
- R4: Writes to the two PCI command registers (0xC00, 0xC80) are ANDed with 0x0401FC0F. Writes to the configuration-address register (0xCF8) are ANDed with 0x80FFFFFC.
- R5: Writes to the multi-bridge register (0x120), the error registers (0x070, 0x078, 0x128, 0x130, 0x138), the sync registers and the ECC registers (0x480 to 0x490) change nothing that can be read.
- R6: A read of either sync register (0x0C0, 0x0C8) returns 0xC000FFEE.
- R7: After reset the windows hold low/high values of 0x080/0x00F, 0x090/0x01F, 0x790/0x01F, 0x100/0x00F, 0x110/0x01F and 0x120/0x02F, and each remap register equals its window's low value. The error data registers (0x128, 0x130) read 0xFFFFFFFF, the parity register (0x138) reads 0x000000FF, and the four SDRAM parameter registers (0x44C to 0x458) read 0x00000005.
- R8: With the big-endian option clear, the CPU configuration register (0x000) resets to 0x00000800 and both command registers reset to 0x00010001. With the option set, all three reset to 0.
- R9: With the big-endian option set, write data is byte-reversed before its mask is applied and read data is byte-reversed on the way out.
- R10: Offsets not named in these requirements read 0, and writes to them have no effect.
- R11: Read data appears one clock after the cycle in which read enable is high, and it holds while read enable is low. A read and a write to the same word in one cycle return the value from before the write.
- R12: The decode outputs carry window k's low value in win_lo_o[15k+14:15k] and its high value in win_hi_o[7k+6:7k]. They change only in the cycle after a write.
- R13: The CPU configuration register and the SDRAM parameter registers store all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address inside the window |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| rdata | output | DATA_W | Registered read data |
| win_lo_o | output | NWIN*15 | Low-decode value of each window |
| win_hi_o | output | NWIN*7 | High-decode value of each window |

## Verification
All-ones write data goes to every masked register class: low-decode, high-decode, remap, command and configuration address. A mask that is too wide or too narrow therefore shows up as a wrong bit. A write of a pattern whose low bits differ between the two masks to one low-decode register shows whether the remap copy uses its own narrower mask and lands in the matching window. Writes to read-only and unlisted offsets, followed by read-back, separate "ignored" from "stored". A big-endian instance driven with byte-asymmetric words shows whether the swap is applied before the mask and again on the way out. A read and a write issued together to one word show whether the old or the new value is returned.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   localparam int IDX_W  = 10;
   localparam int LO_W   = 15;
   localparam int HI_W   = 7;
   localparam int RMP_W  = 11;
   localparam int MAX_WIN = 6;
   localparam int N_CMD  = 2;
   localparam int N_SDP  = 4;

   typedef logic [IDX_W-1:0] widx_t;

   localparam widx_t IDX_CPU_CFG  = 10'h000;
   localparam widx_t IDX_MULTI    = 10'h048;
   localparam widx_t IDX_ERR_ALO  = 10'h01C;
   localparam widx_t IDX_ERR_AHI  = 10'h01E;
   localparam widx_t IDX_ERR_DLO  = 10'h04A;
   localparam widx_t IDX_ERR_DHI  = 10'h04C;
   localparam widx_t IDX_ERR_PAR  = 10'h04E;
   localparam widx_t IDX_SYNC0    = 10'h030;
   localparam widx_t IDX_SYNC1    = 10'h032;
   localparam widx_t IDX_ECC_BASE = 10'h120;
   localparam widx_t IDX_SDP_BASE = 10'h113;
   localparam widx_t IDX_CFG_ADDR = 10'h33E;

   localparam logic [31:0] MSK_LO      = 32'h0000_7FFF;
   localparam logic [31:0] MSK_HI      = 32'h0000_007F;
   localparam logic [31:0] MSK_RMP     = 32'h0000_07FF;
   localparam logic [31:0] MSK_CMD     = 32'h0401_FC0F;
   localparam logic [31:0] MSK_CFG     = 32'h80FF_FFFC;
   localparam logic [31:0] SYNC_WORD   = 32'hC000_FFEE;
   localparam logic [31:0] ERR_DATA_RV = 32'hFFFF_FFFF;
   localparam logic [31:0] ERR_PAR_RV  = 32'h0000_00FF;
   localparam logic [31:0] SDP_RV      = 32'h0000_0005;
   localparam logic [31:0] CPU_CFG_LE  = 32'h0000_0800;
   localparam logic [31:0] CMD_LE      = 32'h0001_0001;

   function automatic widx_t win_lo_idx(input int k);
      case (k)
         0: return 10'h012;
         1: return 10'h016;
         2: return 10'h020;
         3: return 10'h024;
         4: return 10'h028;
         default: return 10'h02C;
      endcase
   endfunction

   function automatic widx_t win_hi_idx(input int k);
      case (k)
         0: return 10'h014;
         1: return 10'h018;
         2: return 10'h022;
         3: return 10'h026;
         4: return 10'h02A;
         default: return 10'h02E;
      endcase
   endfunction

   function automatic widx_t win_rmp_idx(input int k);
      return widx_t'(10'h03C + 2 * k);
   endfunction

   function automatic logic [LO_W-1:0] win_lo_rst(input int k);
      case (k)
         0: return 15'h080;
         1: return 15'h090;
         2: return 15'h790;
         3: return 15'h100;
         4: return 15'h110;
         default: return 15'h120;
      endcase
   endfunction

   function automatic logic [HI_W-1:0] win_hi_rst(input int k);
      case (k)
         0: return 7'h0F;
         1: return 7'h1F;
         2: return 7'h1F;
         3: return 7'h0F;
         4: return 7'h1F;
         default: return 7'h2F;
      endcase
   endfunction

   function automatic widx_t cmd_idx(input int k);
      return (k == 0) ? 10'h300 : 10'h320;
   endfunction

endpackage

// File: rtl/hbr_swap.sv
module hbr_swap #(
   parameter bit ENABLE = 1'b0,
   parameter int W      = 32
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int NB = W / 8;

   generate
      if (ENABLE) begin : g_rev
         for (genvar b = 0; b < NB; b++) begin : g_byte
            assign dout[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/hbr_window_bank.sv
module hbr_window_bank
   import hbr_pkg::*;
#(
   parameter int NWIN = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  widx_t              widx,
   input  logic [LO_W-1:0]    wlo,
   output logic [NWIN*LO_W-1:0]  lo_flat,
   output logic [NWIN*HI_W-1:0]  hi_flat,
   output logic [NWIN*RMP_W-1:0] rmp_flat
);
   generate
      for (genvar k = 0; k < NWIN; k++) begin : g_win
         localparam widx_t LO_I  = win_lo_idx(k);
         localparam widx_t HI_I  = win_hi_idx(k);
         localparam widx_t RMP_I = win_rmp_idx(k);
         localparam logic [LO_W-1:0] LO_RV = win_lo_rst(k);
         localparam logic [HI_W-1:0] HI_RV = win_hi_rst(k);

         logic [LO_W-1:0]  lo_q;
         logic [HI_W-1:0]  hi_q;
         logic [RMP_W-1:0] rmp_q;
         logic hit_lo, hit_hi, hit_rmp;

         assign hit_lo  = wr_en && (widx == LO_I);
         assign hit_hi  = wr_en && (widx == HI_I);
         assign hit_rmp = wr_en && (widx == RMP_I);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q  <= LO_RV;
               hi_q  <= HI_RV;
               rmp_q <= LO_RV[RMP_W-1:0];
            end else begin
               if (hit_lo)
                  lo_q <= wlo & MSK_LO[LO_W-1:0];
               if (hit_hi)
                  hi_q <= wlo[HI_W-1:0] & MSK_HI[HI_W-1:0];
               if (hit_lo || hit_rmp)
                  rmp_q <= wlo[RMP_W-1:0] & MSK_RMP[RMP_W-1:0];
            end
         end

         assign lo_flat[k*LO_W +: LO_W]    = lo_q;
         assign hi_flat[k*HI_W +: HI_W]    = hi_q;
         assign rmp_flat[k*RMP_W +: RMP_W] = rmp_q;
      end
   endgenerate
endmodule

// File: rtl/hbr_misc_regs.sv
module hbr_misc_regs
   import hbr_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b0,
   parameter int DATA_W     = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  widx_t                   widx,
   input  logic [DATA_W-1:0]       wd,
   output logic [DATA_W-1:0]       cpu_cfg,
   output logic [DATA_W-1:0]       cfg_addr,
   output logic [N_CMD*DATA_W-1:0] cmd_flat,
   output logic [N_SDP*DATA_W-1:0] sdp_flat
);
   localparam logic [DATA_W-1:0] CPU_RV = BIG_ENDIAN ? '0 : DATA_W'(CPU_CFG_LE);
   localparam logic [DATA_W-1:0] CMD_RV = BIG_ENDIAN ? '0 : DATA_W'(CMD_LE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_cfg  <= CPU_RV;
         cfg_addr <= '0;
      end else if (wr_en) begin
         if (widx == IDX_CPU_CFG)
            cpu_cfg <= wd;
         if (widx == IDX_CFG_ADDR)
            cfg_addr <= wd & DATA_W'(MSK_CFG);
      end
   end

   generate
      for (genvar c = 0; c < N_CMD; c++) begin : g_cmd
         localparam widx_t CI = cmd_idx(c);
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= CMD_RV;
            else if (wr_en && widx == CI)
               q <= wd & DATA_W'(MSK_CMD);
         end
         assign cmd_flat[c*DATA_W +: DATA_W] = q;
      end

      for (genvar s = 0; s < N_SDP; s++) begin : g_sdp
         localparam widx_t SI = widx_t'(IDX_SDP_BASE + s);
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= DATA_W'(SDP_RV);
            else if (wr_en && widx == SI)
               q <= wd;
         end
         assign sdp_flat[s*DATA_W +: DATA_W] = q;
      end
   endgenerate
endmodule

// File: rtl/hbr_rd_mux.sv
module hbr_rd_mux
   import hbr_pkg::*;
#(
   parameter int NWIN   = 6,
   parameter int DATA_W = 32
) (
   input  widx_t                      widx,
   input  logic [NWIN*LO_W-1:0]       lo_flat,
   input  logic [NWIN*HI_W-1:0]       hi_flat,
   input  logic [NWIN*RMP_W-1:0]      rmp_flat,
   input  logic [DATA_W-1:0]          cpu_cfg,
   input  logic [DATA_W-1:0]          cfg_addr,
   input  logic [N_CMD*DATA_W-1:0]    cmd_flat,
   input  logic [N_SDP*DATA_W-1:0]    sdp_flat,
   output logic [DATA_W-1:0]          rd_word
);
   always_comb begin
      rd_word = '0;
      case (widx)
         IDX_SYNC0, IDX_SYNC1:     rd_word = DATA_W'(SYNC_WORD);
         IDX_ERR_DLO, IDX_ERR_DHI: rd_word = DATA_W'(ERR_DATA_RV);
         IDX_ERR_PAR:              rd_word = DATA_W'(ERR_PAR_RV);
         IDX_CPU_CFG:              rd_word = cpu_cfg;
         IDX_CFG_ADDR:             rd_word = cfg_addr;
         default:                  rd_word = '0;
      endcase
      for (int k = 0; k < NWIN; k++) begin
         if (widx == win_lo_idx(k))
            rd_word = DATA_W'(lo_flat[k*LO_W +: LO_W]);
         if (widx == win_hi_idx(k))
            rd_word = DATA_W'(hi_flat[k*HI_W +: HI_W]);
         if (widx == win_rmp_idx(k))
            rd_word = DATA_W'(rmp_flat[k*RMP_W +: RMP_W]);
      end
      for (int c = 0; c < N_CMD; c++)
         if (widx == cmd_idx(c))
            rd_word = cmd_flat[c*DATA_W +: DATA_W];
      for (int s = 0; s < N_SDP; s++)
         if (widx == widx_t'(IDX_SDP_BASE + s))
            rd_word = sdp_flat[s*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
   import hbr_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int NWIN       = 6,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   input  logic                   wr_en,
   input  logic                   rd_en,
   output logic [DATA_W-1:0]      rdata,
   output logic [NWIN*LO_W-1:0]   win_lo_o,
   output logic [NWIN*HI_W-1:0]   win_hi_o
);
   generate
      if (DATA_W != 32) begin : g_bad_dw
         $error("hbr_regfile: DATA_W must be 32");
      end
      if (ADDR_W != IDX_W + 2) begin : g_bad_aw
         $error("hbr_regfile: ADDR_W must cover a 4 KB window");
      end
      if (NWIN < 1 || NWIN > MAX_WIN) begin : g_bad_nw
         $error("hbr_regfile: NWIN out of range");
      end
   endgenerate

   widx_t                     widx;
   logic                      unused_lsb;
   logic [DATA_W-1:0]         wd_int;
   logic [DATA_W-1:0]         rd_word;
   logic [DATA_W-1:0]         rd_bus;
   logic [NWIN*RMP_W-1:0]     rmp_flat;
   logic [DATA_W-1:0]         cpu_cfg;
   logic [DATA_W-1:0]         cfg_addr;
   logic [N_CMD*DATA_W-1:0]   cmd_flat;
   logic [N_SDP*DATA_W-1:0]   sdp_flat;

   assign widx       = addr[ADDR_W-1:2];
   assign unused_lsb = ^addr[1:0];

   hbr_swap #(.ENABLE(BIG_ENDIAN), .W(DATA_W)) u_swap_in (
      .din  (wdata),
      .dout (wd_int)
   );

   hbr_window_bank #(.NWIN(NWIN)) u_windows (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .widx     (widx),
      .wlo      (wd_int[LO_W-1:0]),
      .lo_flat  (win_lo_o),
      .hi_flat  (win_hi_o),
      .rmp_flat (rmp_flat)
   );

   hbr_misc_regs #(.BIG_ENDIAN(BIG_ENDIAN), .DATA_W(DATA_W)) u_misc (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .widx     (widx),
      .wd       (wd_int),
      .cpu_cfg  (cpu_cfg),
      .cfg_addr (cfg_addr),
      .cmd_flat (cmd_flat),
      .sdp_flat (sdp_flat)
   );

   hbr_rd_mux #(.NWIN(NWIN), .DATA_W(DATA_W)) u_rd_mux (
      .widx     (widx),
      .lo_flat  (win_lo_o),
      .hi_flat  (win_hi_o),
      .rmp_flat (rmp_flat),
      .cpu_cfg  (cpu_cfg),
      .cfg_addr (cfg_addr),
      .cmd_flat (cmd_flat),
      .sdp_flat (sdp_flat),
      .rd_word  (rd_word)
   );

   hbr_swap #(.ENABLE(BIG_ENDIAN), .W(DATA_W)) u_swap_out (
      .din  (rd_word),
      .dout (rd_bus)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= rd_bus;
   end
endmodule

// File: rtl/hbr_regfile_chk.sv
module hbr_regfile_chk
   import hbr_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 32,
   parameter int NWIN       = 6,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    addr,
   input logic [DATA_W-1:0]    wdata,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [DATA_W-1:0]    rdata,
   input logic [NWIN*LO_W-1:0] win_lo_o,
   input logic [NWIN*HI_W-1:0] win_hi_o
);
   function automatic logic [31:0] bus_view(input logic [31:0] d);
      return BIG_ENDIAN ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
   endfunction

   widx_t ix;
   logic  unused_chk;
   assign ix         = addr[ADDR_W-1:2];
   assign unused_chk = ^addr[1:0];

   AST_LO_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == win_lo_idx(0)) |=>
         (win_lo_o[LO_W-1:0] == $past(bus_view(wdata) & MSK_LO) )); // R2

   AST_HI_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == win_hi_idx(0)) |=>
         (win_hi_o[HI_W-1:0] == $past(bus_view(wdata) & MSK_HI) )); // R3

   AST_SYNC_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (ix == IDX_SYNC0 || ix == IDX_SYNC1)) |=>
         (rdata == bus_view(SYNC_WORD))); // R6

   AST_PARITY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && ix == IDX_ERR_PAR) |=> (rdata == bus_view(ERR_PAR_RV))); // R5

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R11

   AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(win_lo_o) && $stable(win_hi_o))); // R12
endmodule

bind hbr_regfile hbr_regfile_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWIN(NWIN), .BIG_ENDIAN(BIG_ENDIAN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
   .rd_en(rd_en), .rdata(rdata), .win_lo_o(win_lo_o), .win_hi_o(win_hi_o)
);

// File: tb/hbr_regfile_bench.sv
`timescale 1ns/1ps
module hbr_regfile_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_le, rd_be;
   logic [89:0] lo_le, lo_be;
   logic [41:0] hi_le, hi_be;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   hbr_regfile #(.BIG_ENDIAN(1'b0)) u_hbr_regfile (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rd_le), .win_lo_o(lo_le), .win_hi_o(hi_le)
   );

   hbr_regfile #(.BIG_ENDIAN(1'b1)) u_hbr_regfile_be (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rd_be), .win_lo_o(lo_be), .win_hi_o(hi_be)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset;
      rd(12'h048); chk("R7 win0 low", rd_le, 32'h080);
      rd(12'h050); chk("R7 win0 high", rd_le, 32'h00F);
      rd(12'h100); chk("R7 win2 remap", rd_le, 32'h790);
      chk("R12 win2 low out", 32'(lo_le[44:30]), 32'h790);
      chk("R12 win5 high out", 32'(hi_le[41:35]), 32'h02F);
      chk("R7 be win0 low out", 32'(lo_be[14:0]), 32'h080);
      rd(12'h128); chk("R7 err data", rd_le, 32'hFFFF_FFFF);
      rd(12'h138); chk("R7 parity", rd_le, 32'h0000_00FF);
      rd(12'h454); chk("R7 sdram param", rd_le, 32'h5);
      rd(12'h000); chk("R8 cpu cfg le", rd_le, 32'h0000_0800);
                   chk("R8 cpu cfg be", rd_be, 32'h0);
      rd(12'hC80); chk("R8 cmd1 le", rd_le, 32'h0001_0001);
                   chk("R8 cmd1 be", rd_be, 32'h0);
   endtask

   task automatic t_low_write;
      wr(12'h058, 32'hFFFF_ABCD);
      chk("R12 win1 low out", 32'(lo_le[29:15]), 32'h2BCD);
      rd(12'h058); chk("R2 low mask", rd_le, 32'h2BCD);
      rd(12'h0F8); chk("R2 remap copy", rd_le, 32'h3CD);
      rd(12'h0F0); chk("R2 other remap kept", rd_le, 32'h080);
   endtask

   task automatic t_high_remap;
      wr(12'h050, 32'hFFFF_FFFF);
      chk("R3 high mask out", 32'(hi_le[6:0]), 32'h7F);
      rd(12'h050); chk("R3 high mask", rd_le, 32'h7F);
      wr(12'h100, 32'hFFFF_FFFF);
      rd(12'h100); chk("R3 remap mask", rd_le, 32'h7FF);
      rd(12'h080); chk("R3 low untouched", rd_le, 32'h790);
   endtask

   task automatic t_cmd_cfg;
      wr(12'hC80, 32'hFFFF_FFFF);
      rd(12'hC80); chk("R4 cmd mask", rd_le, 32'h0401_FC0F);
      wr(12'hCF8, 32'hFFFF_FFFF);
      rd(12'hCF8); chk("R4 cfg addr mask", rd_le, 32'h80FF_FFFC);
   endtask

   task automatic t_readonly;
      wr(12'h138, 32'h0);
      rd(12'h138); chk("R5 parity ignores write", rd_le, 32'hFF);
      wr(12'h120, 32'hFFFF_FFFF);
      rd(12'h120); chk("R5 multi ignores write", rd_le, 32'h0);
      wr(12'h480, 32'h1234_5678);
      rd(12'h480); chk("R5 ecc ignores write", rd_le, 32'h0);
      wr(12'h070, 32'hFFFF_FFFF);
      rd(12'h070); chk("R5 err addr ignores write", rd_le, 32'h0);
      wr(12'h0C0, 32'h0);
      rd(12'h0C0); chk("R6 sync0", rd_le, 32'hC000_FFEE);
      rd(12'h0C8); chk("R6 sync1", rd_le, 32'hC000_FFEE);
   endtask

   task automatic t_offsets;
      wr(12'h44F, 32'h1234_5678);
      rd(12'h44C); chk("R1 byte lanes ignored", rd_le, 32'h1234_5678);
      rd(12'h44E); chk("R1 read at odd byte", rd_le, 32'h1234_5678);
      wr(12'h000, 32'hDEAD_BEEF);
      rd(12'h000); chk("R13 cpu cfg full", rd_le, 32'hDEAD_BEEF);
   endtask

   task automatic t_unlisted;
      wr(12'h800, 32'hFFFF_FFFF);
      rd(12'h800); chk("R10 unlisted write ignored", rd_le, 32'h0);
      rd(12'hCFC); chk("R10 unlisted read zero", rd_le, 32'h0);
   endtask

   task automatic t_latency;
      rd(12'h450); chk("R11 read value", rd_le, 32'h5);
      @(negedge clk);
      addr = 12'h0C0;
      @(negedge clk);
      chk("R11 hold when idle", rd_le, 32'h5);
      @(negedge clk);
      addr = 12'h454; wdata = 32'h0000_AAAA; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R11 read before write", rd_le, 32'h5);
      rd(12'h454); chk("R13 sdram full", rd_le, 32'h0000_AAAA);
   endtask

   task automatic t_swap;
      wr(12'h048, 32'h3412_0000);
      chk("R9 be low swapped in", 32'(lo_be[14:0]), 32'h1234);
      rd(12'h048); chk("R9 be low swapped out", rd_be, 32'h3412_0000);
      rd(12'h0C8); chk("R9 be sync", rd_be, 32'hEEFF_00C0);
      wr(12'h458, 32'h1122_3344);
      rd(12'h458); chk("R9 be round trip", rd_be, 32'h1122_3344);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R7 rdata at reset", rd_le, 32'h0);
      t_reset();
      t_low_write();
      t_high_remap();
      t_cmd_cfg();
      t_readonly();
      t_offsets();
      t_unlisted();
      t_latency();
      t_swap();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule